// File: doc/BRIEF.md
# Banked Memory Decoder with DMA Arbitration

This block sits between an 8-bit processor and the memories of a small console. It takes a 16-bit address and picks one target region: fixed ROM bank, switchable ROM bank, video RAM, external RAM, work RAM (the mirror area included), sprite attribute RAM, I/O, high RAM, the interrupt-enable register, or the mapper-control port that takes writes into ROM space. It drives a one-hot select for that region together with an offset local to the region. The region memories return read data over one shared byte input. The block registers that byte and presents it as the response one cycle after the request.

The block holds the work-RAM bank register, so it can form the banked offset for the switchable half of work RAM. While an object DMA transfer runs, it blocks any processor access that would collide with the DMA on a shared internal bus. How the 8 KB slices of the map are grouped onto buses depends on a model-select input. Regions that are blocked, gated or unusable read as 0xFF and ignore writes.

Top module: `bank_mem_decoder`

## Requirements
- R1: For an accepted access, exactly one bit of `regionSel` is set. The bit order is: 0 fixed ROM (0x0000–0x3FFF reads, offset addr[13:0]); 1 switchable ROM (0x4000–0x7FFF reads, offset addr[13:0]); 2 video RAM (0x8000–0x9FFF, offset addr[12:0]); 3 external RAM (0xA000–0xBFFF, offset addr[12:0]); 4 work RAM; 5 sprite RAM (0xFE00–0xFE9F, offset addr[7:0]); 6 I/O (0xFF00–0xFF7F except the bank register, offset addr[6:0]); 7 high RAM (0xFF80–0xFFFE, offset addr[6:0]); 8 interrupt enable (0xFFFF, offset 0); 9 mapper control. `memWe` is high exactly when a select is set and the request is a write.
- R2: Work RAM covers 0xC000–0xFDFF. When addr[12] is 0 (0xC000–0xCFFF, 0xE000–0xEFFF), the offset is {3'b000, addr[11:0]}. When addr[12] is 1 (0xD000–0xDFFF, 0xF000–0xFDFF), the offset is {bank, addr[11:0]}.
- R3: The work-RAM bank register sits at 0xFF70 and resets to 1. A write there stores data[2:0], and a stored value of 0 becomes 1. A read there returns {5'b11111, bank}. Neither access raises any region select. `wramBank` always shows the register.
- R4: A write anywhere in 0x0000–0x7FFF selects only the mapper-control region (bit 9), with offset addr[14:0]. It never selects a ROM region.
- R5: Accesses to 0xFEA0–0xFEFF select nothing, read as 0xFF and ignore writes.
- R6: Sprite RAM is selected only when `videoMode` is 0 or 1. In modes 2 and 3 an access there selects nothing, reads 0xFF and ignores writes.
- R7: Bus groups for the older model (`modelNew`=0), by addr[15:13]: slices 0–3, 5 and 6 are the main bus, slice 4 is the video bus, slice 7 is CPU-internal. While `dmaActive` is high, an access on the same bus as `dmaSrc` selects nothing and reads 0xFF, unless that bus is CPU-internal.
- R8: With `modelNew`=1, slice 6 (0xC000–0xDFFF) is on its own work-RAM bus. DMA from the main bus then leaves it reachable, and DMA from work RAM blocks it.
- R9: While `dmaActive` is high, any access to 0xFE00–0xFE9F selects nothing and reads 0xFF, whatever the video mode and the DMA source.
- R10: A read request gives `rspValid` high on the next cycle, with `rspData` holding the value chosen at the request. A write gives no response.
- R11: With no request, no region select and no `memWe` are raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Processor access request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Processor address |
| reqWdata | input | 8 | Write data |
| rspValid | output | 1 | Read response valid, one cycle after the request |
| rspData | output | 8 | Read response data |
| dmaActive | input | 1 | Object DMA in progress |
| dmaSrc | input | 16 | Current DMA source address |
| videoMode | input | 2 | Current video mode, 0–3 |
| modelNew | input | 1 | 1 = newer model bus grouping |
| regionSel | output | 10 | One-hot region select |
| localAddr | output | 15 | Offset within the selected region |
| memWe | output | 1 | Write strobe to the selected region |
| memWdata | output | 8 | Write data to the regions |
| portRdata | input | 8 | Read data returned by the selected region |
| wramBank | output | 3 | Current work-RAM bank |

## Verification
The bench works through the corners where a decoder most often slips. A bank write of 0 that is stored as 0 would send switchable work-RAM traffic to bank 0. A mirror-area access that ignored addr[12] would alias the wrong bank. Sprite RAM left open during modes 2–3 or during DMA would return live data where 0xFF is due. A bus table with the slice-6 grouping missing or swapped would block work RAM under the wrong model. The bench also sends ROM-space writes, which a faulty decoder would route to ROM instead of the mapper, and probes both edges of each range, including 0xFDFF/0xFE00, 0xFE9F/0xFEA0 and 0xFFFE/0xFFFF, where an off-by-one compare picks the neighbouring region.

// File: rtl/memdec_pkg.sv
package memdec_pkg;

  localparam int NUM_REGIONS = 10;
  localparam int RG_ROM0   = 0;
  localparam int RG_ROMX   = 1;
  localparam int RG_VRAM   = 2;
  localparam int RG_EXTRAM = 3;
  localparam int RG_WRAM   = 4;
  localparam int RG_OAM    = 5;
  localparam int RG_IO     = 6;
  localparam int RG_HRAM   = 7;
  localparam int RG_IE     = 8;
  localparam int RG_MAPPER = 9;

  localparam int WRAM_OFF_W = 12;
  localparam int MAP_OFF_W  = 15;

  localparam logic [15:0] VRAM_BASE   = 16'h8000;
  localparam logic [15:0] EXT_BASE    = 16'hA000;
  localparam logic [15:0] WRAM_BASE   = 16'hC000;
  localparam logic [15:0] MIRROR_BASE = 16'hE000;
  localparam logic [15:0] OAM_BASE    = 16'hFE00;
  localparam logic [15:0] OAM_LAST    = 16'hFE9F;
  localparam logic [15:0] IO_BASE     = 16'hFF00;
  localparam logic [15:0] HRAM_BASE   = 16'hFF80;
  localparam logic [15:0] IE_ADDR     = 16'hFFFF;

  typedef enum logic [1:0] {
    BUS_CPU   = 2'd0,
    BUS_MAIN  = 2'd1,
    BUS_VIDEO = 2'd2,
    BUS_WRAM  = 2'd3
  } bus_e;

  // Internal bus of an address; the 0xC000 slice moves with the model.
  function automatic bus_e busOf(logic [15:0] addr, logic modelNew);
    if (addr < VRAM_BASE)        return BUS_MAIN;
    else if (addr < EXT_BASE)    return BUS_VIDEO;
    else if (addr < WRAM_BASE)   return BUS_MAIN;
    else if (addr < MIRROR_BASE) return modelNew ? BUS_WRAM : BUS_MAIN;
    else                         return BUS_CPU;
  endfunction

  typedef struct packed {
    logic [NUM_REGIONS-1:0] sel;
    logic                   bankWr;
    logic                   bankRd;
  } strobes_t;

endpackage

// File: rtl/memdec_ctrl.sv
module memdec_ctrl
  import memdec_pkg::*;
#(
  parameter logic [15:0] BANK_REG_ADDR = 16'hFF70
) (
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic [15:0] reqAddr,
  input  logic       dmaActive,
  input  logic [15:0] dmaSrc,
  input  logic [1:0] videoMode,
  input  logic       modelNew,
  output strobes_t   strobes
);

  bus_e accBus;
  bus_e srcBus;
  logic inOam;
  logic conflict;

  always_comb begin
    accBus   = busOf(reqAddr, modelNew);
    srcBus   = busOf(dmaSrc, modelNew);
    inOam    = (reqAddr >= OAM_BASE) && (reqAddr <= OAM_LAST);
    // R7 R8 R9: shared-bus and sprite-RAM blocking during DMA
    conflict = dmaActive && (((srcBus != BUS_CPU) && (srcBus == accBus)) || inOam);
  end

  always_comb begin
    strobes = '0;
    if (reqValid && !conflict) begin
      if (!reqAddr[15]) begin
        if (reqWrite)          strobes.sel[RG_MAPPER] = 1'b1;  // R4
        else if (reqAddr[14])  strobes.sel[RG_ROMX]   = 1'b1;
        else                   strobes.sel[RG_ROM0]   = 1'b1;
      end else if (reqAddr < EXT_BASE) begin
        strobes.sel[RG_VRAM] = 1'b1;
      end else if (reqAddr < WRAM_BASE) begin
        strobes.sel[RG_EXTRAM] = 1'b1;
      end else if (reqAddr < OAM_BASE) begin
        strobes.sel[RG_WRAM] = 1'b1;                            // R2
      end else if (reqAddr <= OAM_LAST) begin
        if (videoMode < 2'd2) strobes.sel[RG_OAM] = 1'b1;       // R6
      end else if (reqAddr < IO_BASE) begin
        strobes = '0;                                           // R5
      end else if (reqAddr == BANK_REG_ADDR) begin
        strobes.bankWr = reqWrite;                              // R3
        strobes.bankRd = !reqWrite;
      end else if (reqAddr < HRAM_BASE) begin
        strobes.sel[RG_IO] = 1'b1;
      end else if (reqAddr < IE_ADDR) begin
        strobes.sel[RG_HRAM] = 1'b1;
      end else begin
        strobes.sel[RG_IE] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/memdec_dp.sv
module memdec_dp
  import memdec_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int WBANK_W = 3,
  parameter int LOCAL_W = 15
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [14:0]        addrLow,
  input  logic [DATA_W-1:0]  reqWdata,
  input  strobes_t           strobes,
  input  logic [DATA_W-1:0]  portRdata,
  output logic [LOCAL_W-1:0] localAddr,
  output logic               memWe,
  output logic [DATA_W-1:0]  memWdata,
  output logic [WBANK_W-1:0] wramBank,
  output logic               rspValid,
  output logic [DATA_W-1:0]  rspData
);

  localparam logic [WBANK_W-1:0] BANK_RESET = WBANK_W'(1);

  function automatic logic [LOCAL_W-1:0] offsetFor(int r, logic [14:0] a,
                                                   logic [WBANK_W-1:0] b);
    case (r)
      RG_ROM0, RG_ROMX:  return LOCAL_W'(a[13:0]);
      RG_VRAM, RG_EXTRAM: return LOCAL_W'(a[12:0]);
      RG_WRAM:           return LOCAL_W'({(a[12] ? b : WBANK_W'(0)), a[WRAM_OFF_W-1:0]});
      RG_OAM:            return LOCAL_W'(a[7:0]);
      RG_IO, RG_HRAM:    return LOCAL_W'(a[6:0]);
      RG_MAPPER:         return LOCAL_W'(a[MAP_OFF_W-1:0]);
      default:           return '0;
    endcase
  endfunction

  logic [NUM_REGIONS-1:0][LOCAL_W-1:0] cand;

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_off
    assign cand[r] = strobes.sel[r] ? offsetFor(r, addrLow, wramBank) : '0;
  end

  always_comb begin
    localAddr = '0;
    for (int r = 0; r < NUM_REGIONS; r++) localAddr = localAddr | cand[r];
  end

  assign memWe    = reqWrite && (|strobes.sel);
  assign memWdata = reqWdata;

  logic [DATA_W-1:0] rdNext;
  always_comb begin
    if (strobes.bankRd)
      rdNext = {{(DATA_W-WBANK_W){1'b1}}, wramBank};
    else if (|strobes.sel)
      rdNext = portRdata;
    else
      rdNext = '1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wramBank <= BANK_RESET;
      rspValid <= 1'b0;
      rspData  <= '1;
    end else begin
      if (strobes.bankWr)
        wramBank <= (reqWdata[WBANK_W-1:0] == '0) ? BANK_RESET : reqWdata[WBANK_W-1:0];
      rspValid <= reqValid && !reqWrite;
      if (reqValid && !reqWrite) rspData <= rdNext;
    end
  end

endmodule

// File: rtl/bank_mem_decoder.sv
module bank_mem_decoder
  import memdec_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int WBANK_W = 3,
  parameter logic [15:0] BANK_REG_ADDR = 16'hFF70,
  localparam int LOCAL_W = ((WBANK_W + WRAM_OFF_W) > MAP_OFF_W) ?
                           (WBANK_W + WRAM_OFF_W) : MAP_OFF_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic                   reqWrite,
  input  logic [15:0]            reqAddr,
  input  logic [DATA_W-1:0]      reqWdata,
  output logic                   rspValid,
  output logic [DATA_W-1:0]      rspData,
  input  logic                   dmaActive,
  input  logic [15:0]            dmaSrc,
  input  logic [1:0]             videoMode,
  input  logic                   modelNew,
  output logic [NUM_REGIONS-1:0] regionSel,
  output logic [LOCAL_W-1:0]     localAddr,
  output logic                   memWe,
  output logic [DATA_W-1:0]      memWdata,
  input  logic [DATA_W-1:0]      portRdata,
  output logic [WBANK_W-1:0]     wramBank
);

  strobes_t strobes;

  memdec_ctrl #(.BANK_REG_ADDR(BANK_REG_ADDR)) u_ctrl (
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .dmaActive(dmaActive),
    .dmaSrc   (dmaSrc),
    .videoMode(videoMode),
    .modelNew (modelNew),
    .strobes  (strobes)
  );

  memdec_dp #(.DATA_W(DATA_W), .WBANK_W(WBANK_W), .LOCAL_W(LOCAL_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .addrLow  (reqAddr[14:0]),
    .reqWdata (reqWdata),
    .strobes  (strobes),
    .portRdata(portRdata),
    .localAddr(localAddr),
    .memWe    (memWe),
    .memWdata (memWdata),
    .wramBank (wramBank),
    .rspValid (rspValid),
    .rspData  (rspData)
  );

  assign regionSel = strobes.sel;

endmodule

// File: rtl/memdec_checker.sv
module memdec_checker
  import memdec_pkg::*;
#(
  parameter int WBANK_W = 3,
  parameter logic [15:0] BANK_REG_ADDR = 16'hFF70
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   reqValid,
  input logic                   reqWrite,
  input logic [15:0]            reqAddr,
  input logic                   rspValid,
  input logic                   dmaActive,
  input logic [15:0]            dmaSrc,
  input logic [1:0]             videoMode,
  input logic [NUM_REGIONS-1:0] regionSel,
  input logic                   memWe,
  input logic [WBANK_W-1:0]     wramBank
);

  assert_onehot_sel_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(regionSel));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (regionSel == '0) && !memWe);

  assert_bank_nonzero_R3: assert property (@(posedge clk) disable iff (!rstN)
    wramBank != '0);

  assert_bank_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqWrite && (reqAddr == BANK_REG_ADDR)) |=> $stable(wramBank));

  assert_rom_write_mapper_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && !reqAddr[15]) |->
      !regionSel[RG_ROM0] && !regionSel[RG_ROMX]);

  assert_unusable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqAddr >= 16'hFEA0 && reqAddr < 16'hFF00) |-> (regionSel == '0));

  assert_oam_mode_R6: assert property (@(posedge clk) disable iff (!rstN)
    (videoMode >= 2'd2) |-> !regionSel[RG_OAM]);

  assert_vram_conflict_R7: assert property (@(posedge clk) disable iff (!rstN)
    (dmaActive && dmaSrc[15:13] == 3'd4 && reqAddr[15:13] == 3'd4) |->
      (regionSel == '0));

  assert_dma_oam_R9: assert property (@(posedge clk) disable iff (!rstN)
    (dmaActive && reqAddr >= 16'hFE00 && reqAddr <= 16'hFE9F) |-> !regionSel[RG_OAM]);

  assert_read_rsp_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite) |=> rspValid);

  assert_write_norsp_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && !reqWrite) |=> !rspValid);

endmodule

bind bank_mem_decoder memdec_checker #(
  .WBANK_W(WBANK_W), .BANK_REG_ADDR(BANK_REG_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqAddr(reqAddr), .rspValid(rspValid), .dmaActive(dmaActive),
  .dmaSrc(dmaSrc), .videoMode(videoMode), .regionSel(regionSel),
  .memWe(memWe), .wramBank(wramBank)
);

// File: tb/bank_mem_decoder_tb.sv
`timescale 1ns/1ps
module bank_mem_decoder_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        rspValid;
  logic [7:0]  rspData;
  logic        dmaActive = 1'b0;
  logic [15:0] dmaSrc = '0;
  logic [1:0]  videoMode = '0;
  logic        modelNew = 1'b0;
  logic [9:0]  regionSel;
  logic [14:0] localAddr;
  logic        memWe;
  logic [7:0]  memWdata;
  logic [7:0]  portRdata;
  logic [2:0]  wramBank;

  int checks = 0, failures = 0;
  logic [2:0] bankM = 3'd1;

  always #4 clk = ~clk;

  bank_mem_decoder u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rspValid(rspValid), .rspData(rspData),
    .dmaActive(dmaActive), .dmaSrc(dmaSrc), .videoMode(videoMode), .modelNew(modelNew),
    .regionSel(regionSel), .localAddr(localAddr), .memWe(memWe), .memWdata(memWdata),
    .portRdata(portRdata), .wramBank(wramBank)
  );

  function automatic logic [7:0] hashRd(int idx, logic [14:0] la);
    return la[7:0] ^ {1'b0, la[14:8]} ^ 8'(idx * 29 + 7);
  endfunction

  // Region memory model: answers from the select and the offset.
  always_comb begin
    int idx;
    idx = 0;
    for (int r = 0; r < 10; r++) if (regionSel[r]) idx = r;
    portRdata = hashRd(idx, localAddr);
  end

  function automatic int busB(logic [15:0] a, logic mdl);
    if (a < 16'h8000) return 1;
    if (a < 16'hA000) return 2;
    if (a < 16'hC000) return 1;
    if (a < 16'hE000) return mdl ? 3 : 1;
    return 0;
  endfunction

  // -1 none, 0..9 region, 10 bank read, 11 bank write
  function automatic int expIdx(logic [15:0] a, logic wr, logic dma,
                                logic [15:0] src, logic [1:0] mode, logic mdl);
    int sb;
    sb = busB(src, mdl);
    if (dma && ((sb != 0 && sb == busB(a, mdl)) || (a >= 16'hFE00 && a <= 16'hFE9F)))
      return -1;
    if (a < 16'h8000) return wr ? 9 : (a[14] ? 1 : 0);
    if (a < 16'hA000) return 2;
    if (a < 16'hC000) return 3;
    if (a < 16'hFE00) return 4;
    if (a <= 16'hFE9F) return (mode < 2) ? 5 : -1;
    if (a < 16'hFF00) return -1;
    if (a == 16'hFF70) return wr ? 11 : 10;
    if (a < 16'hFF80) return 6;
    if (a < 16'hFFFF) return 7;
    return 8;
  endfunction

  function automatic logic [14:0] expLocal(int idx, logic [15:0] a, logic [2:0] b);
    case (idx)
      0, 1: return 15'(a[13:0]);
      2, 3: return 15'(a[12:0]);
      4:    return {(a[12] ? b : 3'd0), a[11:0]};
      5:    return 15'(a[7:0]);
      6, 7: return 15'(a[6:0]);
      9:    return a[14:0];
      default: return '0;
    endcase
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic access(string tag, logic wr, logic [15:0] a, logic [7:0] d,
                        logic dma, logic [15:0] src, logic [1:0] mode, logic mdl);
    int ei;
    logic [9:0] es;
    logic [7:0] ed;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    dmaActive = dma; dmaSrc = src; videoMode = mode; modelNew = mdl;
    #1;
    ei = expIdx(a, wr, dma, src, mode, mdl);
    es = (ei >= 0 && ei < 10) ? 10'(1 << ei) : 10'd0;
    check(regionSel == es, tag, "regionSel", 32'(regionSel), 32'(es));
    check(memWe == (wr && es != 0), tag, "memWe", 32'(memWe), 32'(wr && es != 0));
    if (es != 0)
      check(localAddr == expLocal(ei, a, bankM), tag, "localAddr",
            32'(localAddr), 32'(expLocal(ei, a, bankM)));
    if (ei == 10) ed = {5'b11111, bankM};
    else if (es != 0) ed = hashRd(ei, expLocal(ei, a, bankM));
    else ed = 8'hFF;
    @(posedge clk); #1;
    if (ei == 11) bankM = (d[2:0] == 3'd0) ? 3'd1 : d[2:0];
    if (!wr) begin
      check(rspValid == 1'b1, "R10", "rspValid", 32'(rspValid), 32'd1);
      check(rspData == ed, tag, "rspData", 32'(rspData), 32'(ed));
    end else begin
      check(rspValid == 1'b0, "R10", "rspValid after write", 32'(rspValid), 32'd0);
    end
    check(wramBank == bankM, "R3", "wramBank", 32'(wramBank), 32'(bankM));
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] ra;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1; #1;
    check(wramBank == 3'd1, "R3", "reset bank", 32'(wramBank), 32'd1);
    check(rspValid == 1'b0, "R10", "reset rspValid", 32'(rspValid), 32'd0);
    check(regionSel == '0 && !memWe, "R11", "idle selects", 32'(regionSel), 32'd0);

    // R1 range edges
    access("R1", 0, 16'h3FFF, 0, 0, 0, 0, 0);
    access("R1", 0, 16'h4000, 0, 0, 0, 0, 0);
    access("R1", 0, 16'h9FFF, 0, 0, 0, 0, 0);
    access("R1", 1, 16'hA001, 8'h5A, 0, 0, 0, 0);
    access("R1", 0, 16'hFF7F, 0, 0, 0, 0, 0);
    access("R1", 0, 16'hFF80, 0, 0, 0, 0, 0);
    access("R1", 0, 16'hFFFE, 0, 0, 0, 0, 0);
    access("R1", 1, 16'hFFFF, 8'h1F, 0, 0, 0, 0);
    // R4 mapper writes
    access("R4", 1, 16'h2100, 8'h03, 0, 0, 0, 0);
    access("R4", 1, 16'h7FFF, 8'h03, 0, 0, 0, 0);
    // R3 bank register
    access("R3", 1, 16'hFF70, 8'hF5, 0, 0, 0, 0);
    access("R3", 0, 16'hFF70, 0, 0, 0, 0, 0);
    access("R2", 0, 16'hD123, 0, 0, 0, 0, 0);
    access("R2", 0, 16'hF123, 0, 0, 0, 0, 0);
    access("R2", 0, 16'hE123, 0, 0, 0, 0, 0);
    access("R2", 0, 16'hFDFF, 0, 0, 0, 0, 0);
    access("R3", 1, 16'hFF70, 8'hF8, 0, 0, 0, 0);
    access("R3", 0, 16'hFF70, 0, 0, 0, 0, 0);
    access("R2", 1, 16'hD7FF, 8'h11, 0, 0, 0, 0);
    // R5 unusable
    access("R5", 0, 16'hFEA0, 0, 0, 0, 0, 0);
    access("R5", 1, 16'hFEFF, 8'h22, 0, 0, 0, 0);
    // R6 sprite gating
    access("R6", 0, 16'hFE9F, 0, 0, 0, 2'd1, 0);
    access("R6", 0, 16'hFE00, 0, 0, 0, 2'd2, 0);
    access("R6", 1, 16'hFE10, 8'h33, 0, 0, 2'd3, 0);
    // R7 older-model conflicts
    access("R7", 0, 16'h8800, 0, 1, 16'h9000, 0, 0);
    access("R7", 0, 16'h1234, 0, 1, 16'hC100, 0, 0);
    access("R7", 0, 16'h8800, 0, 1, 16'hC100, 0, 0);
    access("R7", 0, 16'hFF85, 0, 1, 16'hFE00, 0, 0);
    // R8 newer model
    access("R8", 0, 16'hC010, 0, 1, 16'h0100, 0, 1);
    access("R8", 0, 16'hC010, 0, 1, 16'hD000, 0, 1);
    access("R8", 0, 16'hA010, 0, 1, 16'hD000, 0, 1);
    access("R8", 0, 16'hC010, 0, 1, 16'h0100, 0, 0);
    // R9 sprite RAM under DMA
    access("R9", 0, 16'hFE40, 0, 1, 16'hE000, 2'd0, 0);
    access("R9", 1, 16'hFE00, 8'h44, 1, 16'hFF00, 2'd1, 1);
    // Random mix
    for (int i = 0; i < 1500; i++) begin
      case ($urandom_range(0, 3))
        0: ra = 16'hFE00 + 16'($urandom_range(0, 511));
        1: ra = 16'hC000 + 16'($urandom_range(0, 16'h3FFF));
        default: ra = 16'($urandom);
      endcase
      access("R1", 1'($urandom), ra, 8'($urandom), ($urandom_range(0, 3) == 0),
             16'($urandom), 2'($urandom), 1'($urandom));
    end
    @(negedge clk); reqValid = 1'b0; #1;
    check(regionSel == '0 && !memWe, "R11", "idle after run", 32'(regionSel), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule